// File: doc/BRIEF.md
# LCD Display/Command Mode Sequencer

This block decides when an LCD controller refreshes the panel continuously and when it pauses so the host can send configuration words to the panel. The host pushes 16-bit command words into a small first-in first-out queue. The queue feeds a ready/valid port towards the panel command path. The queue keeps draining in every mode.

A pulse on `enterReq` asks for command mode. The sequencer does not stop right away. It first waits until every queued word has gone out. It then lets the frame in progress finish, and it halts scan-out only on the next vsync pulse. Only then does it raise the idle status bit. A pulse on `exitReq` returns the block to display. For a panel with an RGB interface there is one extra cycle that restarts hsync/vsync generation before scan-out resumes. For other panels, scan-out resumes directly.

The enable outputs `scanEn` and `syncEn` go to the timing generator. Two 16-bit status words report the queue state and the engine state.

Top module: `lcd_mode_seq`

## Requirements
- R1: After reset the sequencer is in display mode. `scanEn` is 1, `syncEn` equals `rgbMode`, the idle bit is 0, the queue is empty and the overflow bit is 0.
- R2: Queued words leave on `panelCmdData` in write order, one per cycle in which `panelCmdValid` and `panelCmdReady` are both 1. `statusQueue` bit 15 is 1 exactly when the queue holds no word, and `panelCmdValid` is then 0.
- R3: A write while the queue holds DEPTH words is dropped, even when a word leaves in the same cycle. The drop sets `statusQueue` bit 0, which stays 1 until reset.
- R4: An `enterReq` in display mode starts a drain phase. Scan-out continues through this phase, and the phase lasts until the queue is empty.
- R5: After the drain, the sequencer waits for a `vsync` pulse that arrives after the drain has completed. A vsync during the drain does not count. On that pulse `scanEn` drops and command mode begins.
- R6: `statusLcd` bit 12 is 1 only in command mode. It clears in the first cycle of the sync-restart step, and `scanEn` is 0 while it is 1.
- R7: With `rgbMode` at 1, an `exitReq` in command mode gives exactly one cycle with `syncEn`=1 and `scanEn`=0. Display mode with `scanEn`=1 follows.
- R8: With `rgbMode` at 0, an `exitReq` in command mode returns straight to display mode, and `syncEn` stays 0.
- R9: `exitReq` has no effect outside command mode. `enterReq` has no effect outside display mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Host writes `cmdWrData` into the queue |
| cmdWrData | input | 16 | Host command word |
| enterReq | input | 1 | Pulse: request command mode |
| exitReq | input | 1 | Pulse: request return to display |
| vsync | input | 1 | Frame-end pulse from the timing generator |
| rgbMode | input | 1 | 1 when the panel uses the RGB interface |
| panelCmdReady | input | 1 | Panel command path accepts a word |
| panelCmdValid | output | 1 | Queue head is valid |
| panelCmdData | output | 16 | Queue head word |
| scanEn | output | 1 | Scan-out enable to the timing generator |
| syncEn | output | 1 | hsync/vsync generation enable |
| statusQueue | output | 16 | Bit 15 queue empty, bit 0 sticky overflow, others 0 |
| statusLcd | output | 16 | Bit 12 engine idle, others 0 |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the queue's last pop and a vsync pulse. The bench drains the final word in one cycle and pulses vsync in the cycle after. That vsync falls while the drain phase is still registered, so it must be ignored. The bench then requires one more vsync before the idle bit appears.

The second pair is a host write and a pop on a full queue. The bench fills the queue and then writes while the panel accepts a word. It confirms the drop by reading the remaining words back in order, with no trace of the dropped word, and by seeing the overflow bit set.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  localparam int STAT_W    = 16;
  localparam int EMPTY_BIT = 15;  // queue empty flag in statusQueue
  localparam int OVF_BIT   = 0;   // sticky overflow in statusQueue
  localparam int IDLE_BIT  = 12;  // engine idle in statusLcd

  typedef enum logic [2:0] {
    ST_DISPLAY,
    ST_DRAIN_WAIT,
    ST_STOP_VSYNC,
    ST_IDLE_CMD,
    ST_SYNC_RESTART
  } seqState_t;

  typedef struct packed {
    logic idle;
    logic scan;
    logic sync;
  } seqStrobe_t;
endpackage

// File: rtl/lcdseq_queue.sv
module lcdseq_queue #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdReady,
  output logic             rdValid,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             full, push, pop;

  assign full    = (count == FULL_C);
  assign empty   = (count == '0);
  assign push    = wrEn && !full;
  assign pop     = rdReady && !empty;
  assign rdValid = !empty;
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_C) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_C) ? '0 : rdPtr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (wrEn && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enterReq,
  input  logic       exitReq,
  input  logic       vsync,
  input  logic       rgbMode,
  input  logic       qEmpty,
  output seqStrobe_t strobe
);
  seqState_t st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_DISPLAY:      if (enterReq) nxt = ST_DRAIN_WAIT;
      ST_DRAIN_WAIT:   if (qEmpty)   nxt = ST_STOP_VSYNC;
      ST_STOP_VSYNC:   if (vsync)    nxt = ST_IDLE_CMD;
      ST_IDLE_CMD:     if (exitReq)  nxt = rgbMode ? ST_SYNC_RESTART : ST_DISPLAY;
      ST_SYNC_RESTART:               nxt = ST_DISPLAY;
      default:                       nxt = ST_DISPLAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_DISPLAY;
    else       st <= nxt;
  end

  always_comb begin
    strobe.idle = (st == ST_IDLE_CMD);
    strobe.scan = (st == ST_DISPLAY) || (st == ST_DRAIN_WAIT) || (st == ST_STOP_VSYNC);
    strobe.sync = rgbMode && (st != ST_IDLE_CMD);
  end
endmodule

// File: rtl/lcd_mode_seq.sv
module lcd_mode_seq
  import lcdseq_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic              enterReq,
  input  logic              exitReq,
  input  logic              vsync,
  input  logic              rgbMode,
  input  logic              panelCmdReady,
  output logic              panelCmdValid,
  output logic [CMD_W-1:0]  panelCmdData,
  output logic              scanEn,
  output logic              syncEn,
  output logic [STAT_W-1:0] statusQueue,
  output logic [STAT_W-1:0] statusLcd
);
  seqStrobe_t strobe;
  logic       qEmpty, qOverflow;

  lcdseq_queue #(.DEPTH(QDEPTH), .WIDTH(CMD_W)) u_queue (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (cmdWrEn),
    .wrData   (cmdWrData),
    .rdReady  (panelCmdReady),
    .rdValid  (panelCmdValid),
    .rdData   (panelCmdData),
    .empty    (qEmpty),
    .overflow (qOverflow)
  );

  lcdseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enterReq (enterReq),
    .exitReq  (exitReq),
    .vsync    (vsync),
    .rgbMode  (rgbMode),
    .qEmpty   (qEmpty),
    .strobe   (strobe)
  );

  assign scanEn = strobe.scan;
  assign syncEn = strobe.sync;

  always_comb begin
    statusQueue            = '0;
    statusQueue[EMPTY_BIT] = qEmpty;
    statusQueue[OVF_BIT]   = qOverflow;
    statusLcd              = '0;
    statusLcd[IDLE_BIT]    = strobe.idle;
  end
endmodule

// File: rtl/lcd_mode_seq_chk.sv
module lcd_mode_seq_chk
  import lcdseq_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrEn,
  input logic [CMD_W-1:0]  cmdWrData,
  input logic              enterReq,
  input logic              exitReq,
  input logic              vsync,
  input logic              rgbMode,
  input logic              panelCmdReady,
  input logic              panelCmdValid,
  input logic [CMD_W-1:0]  panelCmdData,
  input logic              scanEn,
  input logic              syncEn,
  input logic [STAT_W-1:0] statusQueue,
  input logic [STAT_W-1:0] statusLcd
);
  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    statusQueue[EMPTY_BIT] |-> !panelCmdValid); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusQueue[OVF_BIT] |=> statusQueue[OVF_BIT]); // R3
  AST_IDLE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusLcd[IDLE_BIT]) |-> $past(statusQueue[EMPTY_BIT])); // R4
  AST_IDLE_ON_VSYNC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusLcd[IDLE_BIT]) |-> $past(vsync)); // R5
  AST_IDLE_NO_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    statusLcd[IDLE_BIT] |-> !scanEn); // R6
  AST_RGB_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (statusLcd[IDLE_BIT] && exitReq && rgbMode) |=> (syncEn && !scanEn && !statusLcd[IDLE_BIT])); // R7
  AST_PLAIN_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (statusLcd[IDLE_BIT] && exitReq && !rgbMode) |=> (scanEn && !statusLcd[IDLE_BIT])); // R8
endmodule

bind lcd_mode_seq lcd_mode_seq_chk #(.CMD_W(CMD_W)) u_chk (.*);

// File: tb/lcd_mode_seq_tb.sv
`timescale 1ns/1ps
module lcd_mode_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [15:0] cmdWrData = '0;
  logic        enterReq = 1'b0, exitReq = 1'b0, vsync = 1'b0;
  logic        rgbMode = 1'b1, panelCmdReady = 1'b0;
  logic        panelCmdValid, scanEn, syncEn;
  logic [15:0] panelCmdData, statusQueue, statusLcd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_mode_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .enterReq(enterReq), .exitReq(exitReq), .vsync(vsync), .rgbMode(rgbMode),
    .panelCmdReady(panelCmdReady), .panelCmdValid(panelCmdValid),
    .panelCmdData(panelCmdData), .scanEn(scanEn), .syncEn(syncEn),
    .statusQueue(statusQueue), .statusLcd(statusLcd)
  );

  // inputs  {wr,rdy,ent,ext,vs,rgb}, expected {scan,sync,idle,empty,ovf,valid}
  localparam int NROW = 21;
  localparam logic [11:0] VEC [NROW] = '{
    12'b100001_110001, 12'b100001_110001, 12'b100001_110001, 12'b100001_110001,
    12'b100001_110011, 12'b001001_110011, 12'b010011_110011, 12'b010001_110011,
    12'b010001_110011, 12'b010001_110110, 12'b000011_110110, 12'b000001_110110,
    12'b000011_001110, 12'b100001_001011, 12'b010101_010110, 12'b000001_110110,
    12'b001000_100110, 12'b000000_100110, 12'b000010_001110, 12'b001100_100110,
    12'b000101_110110
  };

  function automatic string rowTag(int r);
    if (r < 4)   return "R2";
    if (r == 4)  return "R3";
    if (r <= 9)  return "R4";
    if (r <= 12) return "R5";
    if (r == 13) return "R6";
    if (r <= 15) return "R7";
    if (r <= 18) return "R8";
    return "R9";
  endfunction

  function automatic logic [5:0] observed();
    return {scanEn, syncEn, statusLcd[12], statusQueue[15], statusQueue[0], panelCmdValid};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [15:0] d, input logic rdy,
                       input logic ent, input logic ext, input logic vs, input logic rgb);
    @(negedge clk);
    cmdWrEn = wr; cmdWrData = d; panelCmdReady = rdy;
    enterReq = ent; exitReq = ext; vsync = vs; rgbMode = rgb;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #0.5;
    // R1 reset state: scan on, sync on (rgb), idle 0, empty 1, ovf 0, valid 0
    check("R1 reset outputs", 32'(observed()), 32'(6'b110100));

    for (int r = 0; r < NROW; r++) begin
      drive(VEC[r][11], 16'hA000 + 16'(r), VEC[r][10], VEC[r][9], VEC[r][8], VEC[r][7], VEC[r][6]);
      check($sformatf("%s table row %0d", rowTag(r), r), 32'(observed()), 32'(VEC[r][5:0]));
      if (r == 5) check("R2 head is first written word", 32'(panelCmdData), 32'hA000);
    end

    // R1 reset again clears sticky overflow
    @(negedge clk) begin rstN = 1'b0; cmdWrEn = 1'b0; exitReq = 1'b0; rgbMode = 1'b0; end
    @(posedge clk); @(negedge clk) rstN = 1'b1;
    #0.5;
    check("R1 reset with rgbMode 0", 32'(observed()), 32'(6'b100100));

    // R3 full queue: write while popping is still dropped
    for (int i = 0; i < 4; i++) drive(1'b1, 16'hB000 + 16'(i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 full queue no overflow yet", 32'(statusQueue), 32'h0000);
    drive(1'b1, 16'hB009, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 overflow on write to full with pop", 32'(statusQueue[0]), 32'd1);
    for (int i = 1; i < 4; i++) begin
      check($sformatf("R2 order word %0d", i), 32'(panelCmdData), 32'hB000 + 32'(i));
      drive(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    check("R3 dropped word absent, queue empty", 32'(statusQueue), 32'h8001);

    // R9 exit in display ignored; R5 vsync in display does not idle
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R9 exit ignored in display", 32'(observed()), 32'(6'b100110));
    // R6 idle bit position in statusLcd after full entry
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R6 statusLcd bit 12 in command mode", 32'(statusLcd), 32'h1000);
    check("R5 scan stopped in command mode", 32'(scanEn), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule